// File: doc/BRIEF.md
# Level-Interrupt GPIO Controller

This block is a register-mapped general-purpose I/O controller for twelve pins, reached over a 32-bit read/write register bus in APB style. Software sets each pin's driven value and output enable, reads back the pin levels after a two-flop synchronizer, and takes level-sensitive interrupts from any pin. Each pin's interrupt polarity can be active-high or active-low.

An active level is latched into a per-pin status bit that software clears by writing a 1. The status bit sets again at once while the source still sits at its active level. A per-pin enable register gates which latched bits reach the single interrupt output. A 32-bit pin-multiplexing word is stored and driven out unchanged for logic outside the block.

Top module: `gpio_lvl_ctrl`

## Requirements
- R1: After reset, every register reads zero, and `pin_out`, `pin_oe`, `mux_ctl` and `irq` are zero.
- R2: Bits 0 to 11 of the register at offset 0x00 drive `pin_out`. Bits 0 to 11 of the register at offset 0x04 drive `pin_oe`. Both take effect on the write's access cycle. Bits 12 to 31 ignore writes and read as zero.
- R3: A read of offset 0x08 returns the pin levels as bits 0 to 11, delayed by two clock flops. Writes to 0x08 have no effect.
- R4: The polarity bit for line i (0 to 7) sits in the register at offset 0x10 at bit 4*i. The polarity bit for line i (8 to 11) sits in the register at offset 0x18 at bit 4*(i-8). A polarity bit of 0 selects active-high and 1 selects active-low. All other bits of both registers read as zero.
- R5: A status bit at offset 0x0C, bit i, sets one cycle after synchronized line i is at its active level. This happens whatever the enable setting. The bit stays set after the source goes inactive.
- R6: Writing 1 to a status bit clears it when its source is inactive. Writing 0 leaves it unchanged.
- R7: If an acknowledge falls in the same cycle as an active level on the same line, the set wins and the status bit stays 1.
- R8: `irq` is high exactly when some bit is set in both the status register and the enable register at offset 0x14. Writing zero to the enable register masks every source.
- R9: The register at offset 0x1C stores all 32 written bits, reads them back, and drives them on `mux_ctl`. It has no other effect.
- R10: A write happens on a cycle where `psel`, `penable` and `pwrite` are all high. `prdata` is a combinational function of `paddr`. Addresses that map to no register read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel | input | 1 | Register bus select |
| penable | input | 1 | Register bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 5 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for `paddr` |
| pin_in | input | 12 | Pin levels from the pads |
| pin_out | output | 12 | Driven pin values |
| pin_oe | output | 12 | Per-pin output enable |
| mux_ctl | output | 32 | Stored pin-multiplexing word |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench sweeps every line under both polarities. A type decode that picked the wrong register or bit position would latch the wrong line, or latch nothing. An acknowledge issued while the source is still active must leave the bit set; a design that let the clear win would drop a live interrupt. The bench also checks that a bit stays set after the source goes away and that a zero write leaves it alone; a design that tracked the level instead of latching it would fail here. Masking with an all-zero enable while status is pending must lower `irq`, and synchronized input reads must ignore writes.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;

  localparam int unsigned BUS_W          = 32;
  localparam int unsigned ADDR_W         = 5;
  localparam int unsigned LINES_PER_TYPE = 8;
  localparam int unsigned TYPE_STRIDE    = 4;

  // Register offsets (software-visible map)
  localparam logic [ADDR_W-1:0] OFS_OUT     = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_OE      = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_IN      = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT    = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_TYPE_LO = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_MASK    = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_TYPE_HI = 5'h18;
  localparam logic [ADDR_W-1:0] OFS_MUX     = 5'h1C;

  // Bits of a type register that hold a polarity for an existing line
  function automatic logic [BUS_W-1:0] type_field_mask(input int unsigned reg_idx,
                                                       input int unsigned n_pins);
    logic [BUS_W-1:0] m;
    m = '0;
    for (int unsigned k = 0; k < LINES_PER_TYPE; k++) begin
      if (reg_idx * LINES_PER_TYPE + k < n_pins) m[k*TYPE_STRIDE] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/gpio_lvl_sync.sv
module gpio_lvl_sync #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] meta_q, meta_d;
  logic [WIDTH-1:0] sync_q, sync_d;

  always_comb begin
    meta_d = async_in;
    sync_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
    end
  end

  assign sync_out = sync_q;

  // R3
  sync_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sync_q == $past(meta_q)));

endmodule

// File: rtl/gpio_lvl_regs.sv
module gpio_lvl_regs
  import gpio_lvl_pkg::*;
#(
  parameter int unsigned N_PINS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [N_PINS-1:0] lvl_sync,
  input  logic [N_PINS-1:0] status,
  output logic [BUS_W-1:0]  rdata,
  output logic [N_PINS-1:0] out_val,
  output logic [N_PINS-1:0] out_en,
  output logic [N_PINS-1:0] irq_en,
  output logic [N_PINS-1:0] pol,
  output logic [N_PINS-1:0] ack,
  output logic [BUS_W-1:0]  mux_word
);

  localparam logic [BUS_W-1:0] TMASK_LO = type_field_mask(0, N_PINS);
  localparam logic [BUS_W-1:0] TMASK_HI = type_field_mask(1, N_PINS);

  logic [N_PINS-1:0] out_q, out_d;
  logic [N_PINS-1:0] oe_q,  oe_d;
  logic [N_PINS-1:0] en_q,  en_d;
  logic [BUS_W-1:0]  tlo_q, tlo_d;
  logic [BUS_W-1:0]  thi_q, thi_d;
  logic [BUS_W-1:0]  mux_q, mux_d;

  // Next-state
  always_comb begin
    out_d = out_q;
    oe_d  = oe_q;
    en_d  = en_q;
    tlo_d = tlo_q;
    thi_d = thi_q;
    mux_d = mux_q;
    if (wr_en) begin
      case (addr)
        OFS_OUT:     out_d = wdata[N_PINS-1:0];
        OFS_OE:      oe_d  = wdata[N_PINS-1:0];
        OFS_MASK:    en_d  = wdata[N_PINS-1:0];
        OFS_TYPE_LO: tlo_d = wdata & TMASK_LO;
        OFS_TYPE_HI: thi_d = wdata & TMASK_HI;
        OFS_MUX:     mux_d = wdata;
        default: ;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= '0;
      en_q  <= '0;
      tlo_q <= '0;
      thi_q <= '0;
      mux_q <= '0;
    end else begin
      out_q <= out_d;
      oe_q  <= oe_d;
      en_q  <= en_d;
      tlo_q <= tlo_d;
      thi_q <= thi_d;
      mux_q <= mux_d;
    end
  end

  // Polarity fan-out: low type register for the first lines, high for the rest
  for (genvar i = 0; i < N_PINS; i++) begin : g_pol
    localparam int unsigned POS = (i % LINES_PER_TYPE) * TYPE_STRIDE;
    if (i < LINES_PER_TYPE) begin : g_lo
      assign pol[i] = tlo_q[POS];
    end else begin : g_hi
      assign pol[i] = thi_q[POS];
    end
  end

  assign ack = (wr_en && (addr == OFS_STAT)) ? wdata[N_PINS-1:0] : '0;

  // Read mux
  always_comb begin
    rdata = '0;
    case (addr)
      OFS_OUT:     rdata[N_PINS-1:0] = out_q;
      OFS_OE:      rdata[N_PINS-1:0] = oe_q;
      OFS_IN:      rdata[N_PINS-1:0] = lvl_sync;
      OFS_STAT:    rdata[N_PINS-1:0] = status;
      OFS_TYPE_LO: rdata             = tlo_q;
      OFS_MASK:    rdata[N_PINS-1:0] = en_q;
      OFS_TYPE_HI: rdata             = thi_q;
      OFS_MUX:     rdata             = mux_q;
      default:     rdata             = '0;
    endcase
  end

  assign out_val  = out_q;
  assign out_en   = oe_q;
  assign irq_en   = en_q;
  assign mux_word = mux_q;

  // R2
  out_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_OUT) |=> (out_val == $past(wdata[N_PINS-1:0])));

  // R9
  mux_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_MUX) |=> (mux_word == $past(wdata)));

  // R9
  mux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == OFS_MUX) |=> $stable(mux_word));

endmodule

// File: rtl/gpio_lvl_irq.sv
module gpio_lvl_irq #(
  parameter int unsigned N_PINS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] lvl_sync,
  input  logic [N_PINS-1:0] pol,
  input  logic [N_PINS-1:0] irq_en,
  input  logic [N_PINS-1:0] ack,
  output logic [N_PINS-1:0] status,
  output logic              irq
);

  logic [N_PINS-1:0] active;
  logic [N_PINS-1:0] stat_q, stat_d;

  // Polarity 1 inverts the sense: a low pin is the active level
  assign active = lvl_sync ^ pol;

  // Set has priority over acknowledge
  always_comb begin
    stat_d = (stat_q & ~ack) | active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign status = stat_q;
  assign irq    = |(stat_q & irq_en);

  // R5 R7
  status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active != '0) |=> ((status & $past(active)) == $past(active)));

  // R6
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status) & ~status) & ~$past(ack)) == '0));

endmodule

// File: rtl/gpio_lvl_ctrl.sv
module gpio_lvl_ctrl
  import gpio_lvl_pkg::*;
#(
  parameter int unsigned N_PINS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [BUS_W-1:0]  pwdata,
  output logic [BUS_W-1:0]  prdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic [BUS_W-1:0]  mux_ctl,
  output logic              irq
);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sq;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_sync_n = rst_sq[1];

  logic              wr_en;
  logic [N_PINS-1:0] lvl_sync;
  logic [N_PINS-1:0] status;
  logic [N_PINS-1:0] irq_en;
  logic [N_PINS-1:0] pol;
  logic [N_PINS-1:0] ack;

  assign wr_en = psel & penable & pwrite;

  gpio_lvl_sync #(.WIDTH(N_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (pin_in),
    .sync_out (lvl_sync)
  );

  gpio_lvl_regs #(.N_PINS(N_PINS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .addr     (paddr),
    .wdata    (pwdata),
    .lvl_sync (lvl_sync),
    .status   (status),
    .rdata    (prdata),
    .out_val  (pin_out),
    .out_en   (pin_oe),
    .irq_en   (irq_en),
    .pol      (pol),
    .ack      (ack),
    .mux_word (mux_ctl)
  );

  gpio_lvl_irq #(.N_PINS(N_PINS)) u_irq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .lvl_sync (lvl_sync),
    .pol      (pol),
    .irq_en   (irq_en),
    .ack      (ack),
    .status   (status),
    .irq      (irq)
  );

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_en == '0) |-> !irq);

  // R8
  irq_pend_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((status & irq_en) != '0) |-> irq);

  // R10
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_en |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

// File: tb/sim_gpio_lvl_ctrl.sv
module sim_gpio_lvl_ctrl;

  logic        clk;
  logic        rst_n;
  logic        psel, penable, pwrite;
  logic [4:0]  paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic [11:0] pins;
  logic [11:0] pin_out, pin_oe;
  logic [31:0] mux_ctl;
  logic        irq;

  int vectors = 0;
  int fails   = 0;
  logic [31:0] rd;
  logic [31:0] tval;
  logic [4:0]  taddr;

  gpio_lvl_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pins),
    .pin_out(pin_out), .pin_oe(pin_oe), .mux_ctl(mux_ctl), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0; pins = '0;
    rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(5);

    // R1: reset state of every register and output
    for (int a = 0; a < 8; a++) begin
      bus_read(5'(a * 4), rd);
      check("R1 reg", rd, 32'h0);
    end
    check("R1 pin_out", {20'h0, pin_out}, 32'h0);
    check("R1 pin_oe", {20'h0, pin_oe}, 32'h0);
    check("R1 mux_ctl", mux_ctl, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);

    // R2: output value and enable, walking and full patterns
    for (int b = 0; b < 12; b++) begin
      bus_write(5'h00, 32'h1 << b);
      check("R2 pin_out walk", {20'h0, pin_out}, 32'h1 << b);
      bus_write(5'h04, ~(32'h1 << b));
      check("R2 pin_oe walk", {20'h0, pin_oe}, {20'h0, ~(12'h1 << b)});
    end
    bus_write(5'h00, 32'hFFFF_FFFF);
    bus_read(5'h00, rd);
    check("R2 out upper bits", rd, 32'h0000_0FFF);
    bus_write(5'h04, 32'hA5A5_A5A5);
    bus_read(5'h04, rd);
    check("R2 oe readback", rd, 32'h0000_05A5);
    bus_write(5'h00, 32'h0);
    bus_write(5'h04, 32'h0);

    // R3: synchronized input, writes ignored
    pins = 12'hA53;
    wait_cyc(3);
    bus_read(5'h08, rd);
    check("R3 input", rd, 32'h0000_0A53);
    bus_write(5'h08, 32'hFFFF_FFFF);
    bus_read(5'h08, rd);
    check("R3 input write ignored", rd, 32'h0000_0A53);
    pins = 12'h000;
    wait_cyc(4);
    bus_write(5'h0C, 32'hFFF);

    // R4: unused type bits read zero
    bus_write(5'h10, 32'hFFFF_FFFF);
    bus_read(5'h10, rd);
    check("R4 type lo field bits", rd, 32'h1111_1111);
    bus_write(5'h18, 32'hFFFF_FFFF);
    bus_read(5'h18, rd);
    check("R4 type hi field bits", rd, 32'h0000_1111);
    bus_write(5'h10, 32'h0);
    bus_write(5'h18, 32'h0);
    wait_cyc(4);
    bus_write(5'h0C, 32'hFFF);

    // R9: mux word
    bus_write(5'h1C, 32'hDEAD_BEEF);
    bus_read(5'h1C, rd);
    check("R9 mux readback", rd, 32'hDEAD_BEEF);
    check("R9 mux port", mux_ctl, 32'hDEAD_BEEF);
    check("R9 mux no side effect", {20'h0, pin_out}, 32'h0);

    // R10: unmapped offset reads zero
    bus_read(5'h02, rd);
    check("R10 unmapped", rd, 32'h0);

    // Sweep every line under both polarities
    for (int ln = 0; ln < 12; ln++) begin
      for (int p = 0; p < 2; p++) begin
        taddr = (ln < 8) ? 5'h10 : 5'h18;
        tval  = (p == 1) ? (32'h1 << (4 * (ln % 8))) : 32'h0;
        bus_write(taddr, tval);
        bus_read(taddr, rd);
        check("R4 polarity position", rd, tval);
        pins[ln] = (p == 1);            // inactive level
        wait_cyc(4);
        bus_write(5'h0C, 32'hFFF);
        bus_write(5'h14, 32'h1 << ln);
        bus_read(5'h0C, rd);
        check("R6 cleared while inactive", rd, 32'h0);
        check("R8 irq idle", {31'h0, irq}, 32'h0);

        pins[ln] = (p == 0);            // active level
        wait_cyc(4);
        bus_read(5'h0C, rd);
        check("R5 status set", rd, 32'h1 << ln);
        check("R8 irq raised", {31'h0, irq}, 32'h1);
        bus_write(5'h14, 32'h0);
        check("R8 all masked", {31'h0, irq}, 32'h0);
        bus_read(5'h0C, rd);
        check("R5 status ignores mask", rd, 32'h1 << ln);
        bus_write(5'h14, 32'h1 << ln);

        bus_write(5'h0C, 32'h1 << ln);  // acknowledge while still active
        bus_read(5'h0C, rd);
        check("R7 set wins over ack", rd, 32'h1 << ln);

        pins[ln] = (p == 1);            // source gone
        wait_cyc(4);
        bus_read(5'h0C, rd);
        check("R5 latched after source gone", rd, 32'h1 << ln);
        bus_write(5'h0C, 32'h0);
        bus_read(5'h0C, rd);
        check("R6 zero write no effect", rd, 32'h1 << ln);
        bus_write(5'h0C, 32'h1 << ln);
        bus_read(5'h0C, rd);
        check("R6 ack clears", rd, 32'h0);
        check("R8 irq dropped", {31'h0, irq}, 32'h0);

        bus_write(taddr, 32'h0);
        pins[ln] = 1'b0;
        wait_cyc(4);
        bus_write(5'h0C, 32'hFFF);
        bus_write(5'h14, 32'h0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule